// File: doc/BRIEF.md
# Dual-Clock Refresh Watchdog

This block guards a system against software that has stopped running. A 32-bit down counter runs on a free-running oscillator clock. Software must keep restarting it by writing a fixed key through an APB slave port, which runs on the separate bus clock. If the counter reaches zero before it is restarted, the block takes one of two actions. In reset mode it sends a reset request of fixed length towards the system reset controller. In interrupt mode it raises a sticky interrupt that software acknowledges.

The watchdog wakes from reset already armed, in reset mode, with a large default reload value. The reload value is 26 bits wide and is zero-extended into the counter. It is handed to the oscillator domain only when a refresh is delivered. After each expiry the counter reloads and keeps running. A missed interrupt therefore shows up again one period later.

Every crossing between the two clocks is synchronised inside the block. Single control bits use flop chains. The reload value travels with a toggle handshake that holds it stable until the other side acknowledges it. Bus reads of the running count return a snapshot that a second request/acknowledge loop refreshes continuously. The bus side never waits: PREADY stays high.

Top module: `apb_watchdog`

## Requirements
- R1: After reset, the control register (offset 0x00) reads 0x1: bit 0 is enable = 1 and bit 1 is mode = 0 (reset mode). The reload register (0x04) reads DEF_LOAD, the status register (0x10) reads 0, and both wdt_irq and wdt_rst_req are low.
- R2: While enabled and not refreshed, the counter steps from the last delivered reload value L down to 0 and expires when it is at 0. It then reloads L and continues, so expiries repeat every L+1 oscillator cycles.
- R3: In reset mode, each expiry drives wdt_rst_req high for exactly RST_CYC oscillator cycles and never sets the interrupt.
- R4: Writing 0xAC15DE42 to offset 0x08 is a refresh. Within a few oscillator cycles the counter is loaded with the zero-extended reload register, so refreshes spaced closer than the period prevent any expiry.
- R5: A write of any other value to offset 0x08 has no effect, so the counter still expires on schedule.
- R6: In interrupt mode (control bit 1 = 1), an expiry sets status bit 0 and wdt_irq. Both stay high, and wdt_rst_req stays low.
- R7: Writing 1 to status bit 0 clears the interrupt. Writing 0 there leaves it set. The interrupt falls only after such a write of 1.
- R8: With control bit 0 = 0, the counter holds its value and nothing expires.
- R9: Offset 0x0C reads a coherent snapshot of the counter. It is never above the reload value, and it decreases over time while counting.
- R10: The reload register keeps only bits 25:0, and bits 31:26 read as zero.
- R11: Reads of unmapped offsets return 0, writes to them change nothing, and pready is always high.
- R12: A refresh that reaches the counter in the same oscillator cycle as the counter's expiry wins: no expiry action follows, and the counter takes the new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | APB bus clock |
| bus_rst_n | input | 1 | Active-low bus-domain reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Always high, no wait states |
| osc_clk | input | 1 | Free-running oscillator clock for the counter |
| osc_rst_n | input | 1 | Active-low oscillator-domain reset |
| wdt_rst_req | output | 1 | Reset request pulse, oscillator domain |
| wdt_irq | output | 1 | Sticky timeout interrupt, bus domain |

## Verification
Two events can fall in the same oscillator cycle: a refresh arriving from the bus domain, and the counter reaching zero. The bench provokes this by sweeping the delay of a second refresh, in bus-clock steps, across the moment of expiry that the first refresh predicts. Because the two clocks are unrelated, some trials land on the exact cycle. Each trial is judged in three ways. There must be at most one reset pulse. Trials well before the boundary must produce none, and trials well after it must produce exactly one. A checker property also requires that no reset pulse ever starts in the cycle after a refresh lands.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

   // Register offsets (byte addresses on the 8-bit bus address)
   localparam logic [7:0] OFS_CTRL   = 8'h00;
   localparam logic [7:0] OFS_RELOAD = 8'h04;
   localparam logic [7:0] OFS_KICK   = 8'h08;
   localparam logic [7:0] OFS_COUNT  = 8'h0C;
   localparam logic [7:0] OFS_STAT   = 8'h10;

   // Control bit positions
   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_MODE_BIT = 1;

   // Refresh key
   localparam logic [31:0] KICK_KEY = 32'hAC15_DE42;

   typedef enum logic {
      MODE_RESET = 1'b0,
      MODE_IRQ   = 1'b1
   } wdt_mode_e;

endpackage

// File: rtl/wdt_sync.sv
`timescale 1ns/1ps
module wdt_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("wdt_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d};
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/wdt_apb_regs.sv
`timescale 1ns/1ps
module wdt_apb_regs
   import wdt_pkg::*;
#(
   parameter int                CNT_W    = 32,
   parameter int                LOAD_W   = 26,
   parameter int                ADDR_W   = 8,
   parameter int                DATA_W   = 32,
   parameter logic [LOAD_W-1:0] DEF_LOAD = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   // APB slave
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   // control towards the oscillator domain
   output logic              ctrl_en,
   output logic              ctrl_mode,
   // refresh handshake
   output logic              kick_req,
   input  logic              kick_ack_s,
   output logic [LOAD_W-1:0] xfer_load,
   // count snapshot handshake
   output logic              snap_req,
   input  logic              snap_ack_s,
   input  logic [CNT_W-1:0]  snap_data,
   // expiry event toggle, already synchronised
   input  logic              evt_s,
   output logic              irq
);

   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
   localparam logic [ADDR_W-1:0] A_KICK   = ADDR_W'(OFS_KICK);
   localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
   localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_STAT);

   logic              wr_acc;
   logic              rd_sel;
   logic              key_hit;
   logic              w1c_hit;
   logic              kick_idle;
   logic              kick_pend_q;
   logic              kick_req_q;
   logic [LOAD_W-1:0] xfer_q;
   logic [LOAD_W-1:0] reload_q;
   logic              en_q;
   logic              mode_q;
   logic              snap_req_q;
   logic [CNT_W-1:0]  cnt_view_q;
   logic              evt_d_q;
   logic              irq_q;

   assign wr_acc    = psel & penable & pwrite;
   assign rd_sel    = psel & ~pwrite;
   assign key_hit   = wr_acc && (paddr == A_KICK) && (pwdata == DATA_W'(KICK_KEY));
   assign w1c_hit   = wr_acc && (paddr == A_STAT) && pwdata[0];
   assign kick_idle = (kick_req_q == kick_ack_s);
   assign pready    = 1'b1;

   // Control and reload registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b1;
         mode_q   <= MODE_RESET;
         reload_q <= DEF_LOAD;
      end else if (wr_acc) begin
         if (paddr == A_CTRL) begin
            en_q   <= pwdata[CTRL_EN_BIT];
            mode_q <= pwdata[CTRL_MODE_BIT];
         end
         if (paddr == A_RELOAD) begin
            reload_q <= pwdata[LOAD_W-1:0];
         end
      end
   end

   // Refresh launch: a key that arrives while a transfer is in flight is merged
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kick_req_q  <= 1'b0;
         kick_pend_q <= 1'b0;
         xfer_q      <= DEF_LOAD;
      end else if (kick_idle && (key_hit || kick_pend_q)) begin
         xfer_q      <= reload_q;
         kick_req_q  <= ~kick_req_q;
         kick_pend_q <= 1'b0;
      end else if (key_hit) begin
         kick_pend_q <= 1'b1;
      end
   end

   // Snapshot loop: capture held data on each returned acknowledge, then ask again
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_req_q <= 1'b0;
         cnt_view_q <= '0;
      end else if (snap_req_q == snap_ack_s) begin
         cnt_view_q <= snap_data;
         snap_req_q <= ~snap_req_q;
      end
   end

   // Sticky interrupt: a new event has priority over a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_d_q <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         evt_d_q <= evt_s;
         if (evt_s ^ evt_d_q) begin
            irq_q <= 1'b1;
         end else if (w1c_hit) begin
            irq_q <= 1'b0;
         end
      end
   end

   // Read data path
   always_comb begin
      prdata = '0;
      if (rd_sel) begin
         case (paddr)
            A_CTRL:   prdata = DATA_W'({mode_q, en_q});
            A_RELOAD: prdata = DATA_W'(reload_q);
            A_COUNT:  prdata = DATA_W'(cnt_view_q);
            A_STAT:   prdata = DATA_W'(irq_q);
            default:  prdata = '0;
         endcase
      end
   end

   assign ctrl_en   = en_q;
   assign ctrl_mode = mode_q;
   assign kick_req  = kick_req_q;
   assign xfer_load = xfer_q;
   assign snap_req  = snap_req_q;
   assign irq       = irq_q;

endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
module wdt_core
   import wdt_pkg::*;
#(
   parameter int                CNT_W    = 32,
   parameter int                LOAD_W   = 26,
   parameter logic [LOAD_W-1:0] DEF_LOAD = '1,
   parameter int                RST_CYC  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_s,
   input  logic              mode_s,
   input  logic              kick_req_s,
   input  logic [LOAD_W-1:0] xfer_load,
   input  logic              snap_req_s,
   output logic [CNT_W-1:0]  snap_data,
   output logic              kick_ack,
   output logic              snap_ack,
   output logic              evt_tgl,
   output logic              rst_req,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              kick_fire_o
);

   localparam logic [CNT_W-1:0] CNT_DEF = CNT_W'(DEF_LOAD);

   logic [CNT_W-1:0]  cnt_q;
   logic [LOAD_W-1:0] load_q;
   logic              kick_ack_q;
   logic              snap_ack_q;
   logic [CNT_W-1:0]  snap_q;
   logic              evt_q;
   logic              kick_fire;
   logic              expire;
   logic              fire_rst;

   assign kick_fire = kick_req_s ^ kick_ack_q;
   // a landing refresh masks expiry in the same cycle
   assign expire    = !kick_fire && en_s && (cnt_q == '0);
   assign fire_rst  = expire && (mode_s == MODE_RESET);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= CNT_DEF;
         load_q     <= DEF_LOAD;
         kick_ack_q <= 1'b0;
      end else if (kick_fire) begin
         cnt_q      <= CNT_W'(xfer_load);
         load_q     <= xfer_load;
         kick_ack_q <= kick_req_s;
      end else if (en_s) begin
         cnt_q <= expire ? CNT_W'(load_q) : cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q <= 1'b0;
      end else if (expire && (mode_s == MODE_IRQ)) begin
         evt_q <= ~evt_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q     <= '0;
         snap_ack_q <= 1'b0;
      end else if (snap_req_s != snap_ack_q) begin
         snap_q     <= cnt_q;
         snap_ack_q <= snap_req_s;
      end
   end

   // Reset request pulse shaping: single flop or down counter
   if (RST_CYC == 1) begin : g_rst_flop
      logic pulse_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse_q <= 1'b0;
         else        pulse_q <= fire_rst;
      end
      assign rst_req = pulse_q;
   end else begin : g_rst_cnt
      localparam int RC_W = $clog2(RST_CYC + 1);
      logic [RC_W-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            left_q <= '0;
         end else if (fire_rst) begin
            left_q <= RC_W'(RST_CYC);
         end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
         end
      end
      assign rst_req = (left_q != '0);
   end

   assign snap_data   = snap_q;
   assign kick_ack    = kick_ack_q;
   assign snap_ack    = snap_ack_q;
   assign evt_tgl     = evt_q;
   assign cnt_o       = cnt_q;
   assign kick_fire_o = kick_fire;

endmodule

// File: rtl/apb_watchdog.sv
`timescale 1ns/1ps
module apb_watchdog #(
   parameter int                CNT_W       = 32,
   parameter int                LOAD_W      = 26,
   parameter int                ADDR_W      = 8,
   parameter int                DATA_W      = 32,
   parameter logic [LOAD_W-1:0] DEF_LOAD    = 26'h3FF_FFFF,
   parameter int                RST_CYC     = 16,
   parameter int                SYNC_STAGES = 2
) (
   input  logic              bus_clk,
   input  logic              bus_rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   input  logic              osc_clk,
   input  logic              osc_rst_n,
   output logic              wdt_rst_req,
   output logic              wdt_irq
);

   localparam int B2O_W = 4;
   localparam int O2B_W = 3;

   if (LOAD_W > CNT_W) begin : g_bad_load
      $error("apb_watchdog: LOAD_W exceeds CNT_W");
   end
   if (DATA_W < CNT_W || DATA_W < 32) begin : g_bad_data
      $error("apb_watchdog: DATA_W too narrow");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("apb_watchdog: ADDR_W too narrow for the register map");
   end
   if (RST_CYC < 1) begin : g_bad_rst
      $error("apb_watchdog: RST_CYC must be positive");
   end

   logic              ctrl_en;
   logic              ctrl_mode;
   logic              kick_req;
   logic              snap_req;
   logic [LOAD_W-1:0] xfer_load;
   logic [CNT_W-1:0]  snap_data;
   logic              kick_ack;
   logic              snap_ack;
   logic              evt_tgl;
   logic              kick_ack_s;
   logic              snap_ack_s;
   logic              evt_s;
   logic              en_s;
   logic              mode_s;
   logic              kick_req_s;
   logic              snap_req_s;
   logic [CNT_W-1:0]  cnt_osc;
   logic              kick_fire;

   wdt_apb_regs #(
      .CNT_W(CNT_W), .LOAD_W(LOAD_W), .ADDR_W(ADDR_W),
      .DATA_W(DATA_W), .DEF_LOAD(DEF_LOAD)
   ) u_regs (
      .clk(bus_clk), .rst_n(bus_rst_n),
      .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
      .ctrl_en(ctrl_en), .ctrl_mode(ctrl_mode),
      .kick_req(kick_req), .kick_ack_s(kick_ack_s), .xfer_load(xfer_load),
      .snap_req(snap_req), .snap_ack_s(snap_ack_s), .snap_data(snap_data),
      .evt_s(evt_s), .irq(wdt_irq)
   );

   // bus -> oscillator: enable resets high so counting starts at once
   wdt_sync #(.WIDTH(B2O_W), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) u_sync_b2o (
      .clk(osc_clk), .rst_n(osc_rst_n),
      .d({snap_req, kick_req, ctrl_mode, ctrl_en}),
      .q({snap_req_s, kick_req_s, mode_s, en_s})
   );

   // oscillator -> bus
   wdt_sync #(.WIDTH(O2B_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_sync_o2b (
      .clk(bus_clk), .rst_n(bus_rst_n),
      .d({evt_tgl, snap_ack, kick_ack}),
      .q({evt_s, snap_ack_s, kick_ack_s})
   );

   wdt_core #(
      .CNT_W(CNT_W), .LOAD_W(LOAD_W), .DEF_LOAD(DEF_LOAD), .RST_CYC(RST_CYC)
   ) u_core (
      .clk(osc_clk), .rst_n(osc_rst_n),
      .en_s(en_s), .mode_s(mode_s),
      .kick_req_s(kick_req_s), .xfer_load(xfer_load),
      .snap_req_s(snap_req_s), .snap_data(snap_data),
      .kick_ack(kick_ack), .snap_ack(snap_ack), .evt_tgl(evt_tgl),
      .rst_req(wdt_rst_req), .cnt_o(cnt_osc), .kick_fire_o(kick_fire)
   );

endmodule

// File: rtl/wdt_chk.sv
`timescale 1ns/1ps
module wdt_chk
   import wdt_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int LOAD_W = 26,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input logic              bus_clk,
   input logic              bus_rst_n,
   input logic              osc_clk,
   input logic              osc_rst_n,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic              pwdata0,
   input logic [DATA_W-1:0] prdata,
   input logic              irq,
   input logic              rst_req,
   input logic              mode_s,
   input logic              en_s,
   input logic              kick_fire,
   input logic [CNT_W-1:0]  cnt,
   input logic [LOAD_W-1:0] xfer_load
);

   logic rd_unmapped;
   assign rd_unmapped = psel && !pwrite &&
                        (paddr != ADDR_W'(OFS_CTRL))   && (paddr != ADDR_W'(OFS_RELOAD)) &&
                        (paddr != ADDR_W'(OFS_KICK))   && (paddr != ADDR_W'(OFS_COUNT))  &&
                        (paddr != ADDR_W'(OFS_STAT));

   // R3
   rst_only_in_reset_mode_chk: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
      $rose(rst_req) |-> ($past(mode_s) == MODE_RESET));

   // R4
   kick_loads_counter_chk: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
      kick_fire |=> (cnt == CNT_W'($past(xfer_load))));

   // R8
   frozen_when_disabled_chk: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
      (!en_s && !kick_fire) |=> $stable(cnt));

   // R12
   kick_beats_expiry_chk: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
      kick_fire |=> !$rose(rst_req));

   // R7
   irq_falls_on_w1c_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      $fell(irq) |-> $past(psel && penable && pwrite && (paddr == ADDR_W'(OFS_STAT)) && pwdata0));

   // R10
   reload_upper_zero_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (psel && !pwrite && (paddr == ADDR_W'(OFS_RELOAD))) |-> (prdata[DATA_W-1:LOAD_W] == '0));

   // R11
   unmapped_reads_zero_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      rd_unmapped |-> (prdata == '0));

endmodule

bind apb_watchdog wdt_chk #(
   .CNT_W(CNT_W), .LOAD_W(LOAD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
   .osc_clk(osc_clk), .osc_rst_n(osc_rst_n),
   .psel(psel), .penable(penable), .pwrite(pwrite),
   .paddr(paddr), .pwdata0(pwdata[0]), .prdata(prdata),
   .irq(wdt_irq), .rst_req(wdt_rst_req),
   .mode_s(mode_s), .en_s(en_s), .kick_fire(kick_fire),
   .cnt(cnt_osc), .xfer_load(xfer_load)
);

// File: tb/test_apb_watchdog.sv
`timescale 1ns/1ps
module test_apb_watchdog;

   localparam int LD   = 50;
   localparam int RCYC = 4;
   localparam logic [31:0] KEY = 32'hAC15_DE42;

   logic        bus_clk = 1'b0;
   logic        osc_clk = 1'b0;
   logic        bus_rst_n = 1'b0;
   logic        osc_rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready;
   logic        wdt_rst_req;
   logic        wdt_irq;

   int total = 0;
   int bad   = 0;
   int osc_tick = 0;
   int rise_q[$];
   int hi_len = 0;
   bit prev_rst = 1'b0;
   bit irq_settled = 1'b0;
   bit finished = 1'b0;

   always #4    bus_clk = ~bus_clk;
   always #15.5 osc_clk = ~osc_clk;

   apb_watchdog #(.DEF_LOAD(26'(LD)), .RST_CYC(RCYC)) i_apb_watchdog (
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
      .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
      .osc_clk(osc_clk), .osc_rst_n(osc_rst_n),
      .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic bus_wait(input int n);
      repeat (n) @(negedge bus_clk);
   endtask

   task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge bus_clk);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
      @(negedge bus_clk);
      penable = 1'b1;
      @(negedge bus_clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge bus_clk);
      psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
      @(negedge bus_clk);
      penable = 1'b1;
      #1 d = prdata;
      @(negedge bus_clk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic kick();
      apb_write(8'h08, KEY);
   endtask

   // Oscillator-side reference: pulse timing and width
   always @(posedge osc_clk) osc_tick++;

   always @(negedge osc_clk) begin
      if (osc_rst_n) begin
         if (wdt_rst_req && !prev_rst) begin
            rise_q.push_back(osc_tick);
            hi_len = 1;
         end else if (wdt_rst_req) begin
            hi_len++;
         end else if (prev_rst) begin
            chk(hi_len == RCYC, "R3 reset pulse width", 32'(hi_len), 32'(RCYC));
         end
         if (irq_settled) chk(!wdt_rst_req, "R6 no reset request in interrupt mode", 32'(wdt_rst_req), 0);
         prev_rst = wdt_rst_req;
      end
   end

   // Bus-side per-cycle check
   always @(negedge bus_clk) begin
      if (bus_rst_n && !finished) chk(pready === 1'b1, "R11 pready high", 32'(pready), 1);
   end

   // Watchdog of the bench itself
   initial begin
      repeat (150000) @(posedge bus_clk);
      if (!finished) begin
         finished = 1'b1;
         chk(1'b0, "watchdog expired", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, c1, c2;
      int n;
      bit got;

      repeat (6) @(negedge bus_clk);
      osc_rst_n = 1'b1;
      bus_rst_n = 1'b1;
      bus_wait(2);

      // R1 reset state
      apb_read(8'h00, v); chk(v == 32'h1, "R1 control reset value", v, 32'h1);
      apb_read(8'h04, v); chk(v == 32'(LD), "R1 reload reset value", v, 32'(LD));
      apb_read(8'h10, v); chk(v == 0, "R1 status reset value", v, 0);
      chk(!wdt_irq, "R1 irq low", 32'(wdt_irq), 0);
      chk(!wdt_rst_req, "R1 reset request low", 32'(wdt_rst_req), 0);

      // R2 free-running period without refresh
      rise_q.delete();
      for (int i = 0; i < 1500 && rise_q.size() < 3; i++) bus_wait(1);
      chk(rise_q.size() >= 3, "R2 repeated expiries", 32'(rise_q.size()), 3);
      if (rise_q.size() >= 3) begin
         chk(rise_q[1] - rise_q[0] == LD + 1, "R2 expiry period", 32'(rise_q[1] - rise_q[0]), 32'(LD + 1));
         chk(rise_q[2] - rise_q[1] == LD + 1, "R2 expiry period again", 32'(rise_q[2] - rise_q[1]), 32'(LD + 1));
      end
      chk(!wdt_irq, "R3 irq untouched in reset mode", 32'(wdt_irq), 0);

      // R9 count snapshot
      kick();
      bus_wait(60);
      apb_read(8'h0C, c1);
      bus_wait(40);
      apb_read(8'h0C, c2);
      chk(c1 <= LD && c1 >= 30, "R9 snapshot within reload", c1, 32'(LD));
      chk(c2 < c1, "R9 snapshot decreasing", c2, c1);

      // R4 periodic refresh holds off expiry
      kick();
      bus_wait(20);
      rise_q.delete();
      for (int i = 0; i < 20; i++) begin
         bus_wait(100);
         kick();
      end
      chk(rise_q.size() == 0, "R4 refresh prevents expiry", 32'(rise_q.size()), 0);

      // R5 wrong key is ignored
      kick();
      bus_wait(20);
      rise_q.delete();
      for (int i = 0; i < 8; i++) begin
         apb_write(8'h08, (i % 2 == 0) ? 32'h0 : (KEY ^ 32'h1));
         bus_wait(40);
      end
      chk(rise_q.size() >= 1, "R5 wrong key does not refresh", 32'(rise_q.size()), 1);

      // R12 collision sweep
      for (int d = 170; d <= 226; d += 4) begin
         kick();
         bus_wait(20);
         rise_q.delete();
         bus_wait(d - 20);
         kick();
         bus_wait(30);
         n = rise_q.size();
         chk(n <= 1, "R12 at most one expiry per trial", 32'(n), 1);
         if (d <= 174) chk(n == 0, "R12 early refresh wins", 32'(n), 0);
         if (d >= 222) chk(n == 1, "R12 late refresh follows expiry", 32'(n), 1);
      end

      // R6 / R7 interrupt mode
      apb_write(8'h00, 32'h3);
      kick();
      bus_wait(40);
      rise_q.delete();
      irq_settled = 1'b1;
      got = 1'b0;
      for (int i = 0; i < 400 && !got; i++) begin bus_wait(1); got = wdt_irq; end
      chk(got, "R6 irq raised on expiry", 32'(got), 1);
      bus_wait(300);
      chk(wdt_irq, "R6 irq held", 32'(wdt_irq), 1);
      apb_read(8'h10, v); chk(v == 32'h1, "R6 status bit set", v, 1);
      chk(rise_q.size() == 0, "R6 no reset pulse", 32'(rise_q.size()), 0);
      apb_write(8'h10, 32'h0);
      bus_wait(2);
      chk(wdt_irq, "R7 write of zero keeps irq", 32'(wdt_irq), 1);
      kick();
      apb_write(8'h10, 32'h1);
      bus_wait(2);
      chk(!wdt_irq, "R7 write of one clears irq", 32'(wdt_irq), 0);
      apb_read(8'h10, v); chk(v == 0, "R7 status cleared", v, 0);
      got = 1'b0;
      for (int i = 0; i < 300 && !got; i++) begin bus_wait(1); got = wdt_irq; end
      chk(got, "R2 counter keeps running after timeout", 32'(got), 1);

      // R8 disable freezes the counter
      apb_write(8'h00, 32'h2);
      bus_wait(40);
      apb_write(8'h10, 32'h1);
      apb_read(8'h00, v); chk(v == 32'h2, "R8 control readback", v, 32'h2);
      bus_wait(40);
      apb_read(8'h0C, c1);
      bus_wait(300);
      apb_read(8'h0C, c2);
      chk(c1 == c2, "R8 count frozen", c2, c1);
      chk(!wdt_irq, "R8 no expiry while disabled", 32'(wdt_irq), 0);

      // R10 reload width
      apb_write(8'h04, 32'hFFFF_FFFF);
      apb_read(8'h04, v); chk(v == 32'h03FF_FFFF, "R10 reload upper bits zero", v, 32'h03FF_FFFF);
      apb_write(8'h04, 32'(LD));

      // R11 unmapped addresses
      apb_write(8'h14, 32'hFFFF_FFFF);
      apb_write(8'hFC, 32'hFFFF_FFFF);
      apb_read(8'h14, v); chk(v == 0, "R11 unmapped read 0x14", v, 0);
      apb_read(8'hFC, v); chk(v == 0, "R11 unmapped read 0xFC", v, 0);
      apb_read(8'h40, v); chk(v == 0, "R11 unmapped read 0x40", v, 0);
      apb_read(8'h00, v); chk(v == 32'h2, "R11 control unchanged", v, 32'h2);
      apb_read(8'h04, v); chk(v == 32'(LD), "R11 reload unchanged", v, 32'(LD));
      apb_read(8'h10, v); chk(v == 0, "R11 status unchanged", v, 0);

      irq_settled = 1'b0;
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule